// File: doc/BRIEF.md
# Cascaded Sample Address Generator

This block produces the write and read address for a sample buffer of 131,072 words. The low sixteen address bits come from a chain of eight-bit counter stages. A dedicated toggle circuit supplies the single bit above them. Each stage keeps a binary counter and a separate parallel output register. Each of the two has its own clock enable, so the presented address can be sampled from the counter on any chosen cycle. When both enables are asserted together, the presented address trails the internal count by exactly one step.

Each stage enables the next through its ripple carry. The ripple carries are exported so that surrounding control logic can watch the stage boundaries. A terminal-count flag is raised while the presented address is at its last location; control logic uses it to switch between acquisition and playback. The presented address can be floated so that other drivers can use the same wires. A synchronous clear returns every counter and register to zero.

Top module: `cascade_addr_gen`

## Requirements
- R1: While the reset is asserted, and during the two clock cycles after it is released, every counter and register is zero. With `out_en` high, `addr_o` reads 0, `tc_o` is 0 and `stage_rco_o` is 0.
- R2: The internal count rises by one, modulo 2^17, on each rising edge at which both `cnt_en` and `cnt_clk_en` are high and `sync_clr` is low.
- R3: On each edge at which `reg_clk_en` is high and `sync_clr` is low, the output register takes the internal count held before that edge. On any other edge it keeps its value. With both clock enables held high, `addr_o` equals the number of edges since the clear minus one.
- R4: `stage_rco_o[0]` is high exactly when the low eight count bits are 0xFF and both `cnt_en` and `cnt_clk_en` are high. `stage_rco_o[1]` is high exactly when `stage_rco_o[0]` is high and count bits 15:8 are 0xFF.
- R5: Bits 15:8 advance only on edges at which `stage_rco_o[0]` is high, so the count goes from 0x000FF to 0x00100.
- R6: Bit 16 toggles on edges at which `stage_rco_o[1]` is high and on no others, so the count goes from 0x0FFFF to 0x10000.
- R7: `tc_o` is high exactly while the output register holds 0x1FFFF. The next advance of the count from 0x1FFFF gives 0.
- R8: While `out_en` is low, `addr_o` is high impedance. The register keeps counting and loading, and its value appears again when `out_en` returns high.
- R9: An edge with `sync_clr` high sets the counter and the register to zero, whatever the enables are.
- R10: With `cnt_en` low or `cnt_clk_en` low, the count does not change, and no ripple carry is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sync_clr | input | 1 | Synchronous clear of counters and registers |
| cnt_en | input | 1 | Count enable into the first stage |
| cnt_clk_en | input | 1 | Clock enable of the counters |
| reg_clk_en | input | 1 | Clock enable of the output registers |
| out_en | input | 1 | High drives `addr_o`, low floats it |
| addr_o | output | 17 | Registered address, tri-state |
| stage_rco_o | output | 2 | Ripple carry of each eight-bit stage |
| tc_o | output | 1 | Output register is at the last address |

## Verification
On every cycle the assertions check the following: the count steps or holds as the enables dictate, the register loads the previous count or keeps its value, the clear empties both, and the top bit toggles only under the upper stage's carry. These checks need the internal count, so they are bound inside. Only the bench scenarios show the port behaviour. This covers the one-step lag seen at `addr_o`, the carry ripple at the 0xFF and 0xFFFF boundaries, the terminal flag and the wrap after a full 131,072-step pass, and the float and return of the address under `out_en`.

// File: rtl/cag_pkg.sv
package cag_pkg;
  localparam int unsigned STAGE_W_DEF = 8;
  localparam int unsigned N_STAGES_DEF = 2;

  typedef struct packed {
    logic clr;
    logic step;
    logic ld;
  } stage_ctl_t;
endpackage

// File: rtl/cag_stage.sv
module cag_stage
  import cag_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  stage_ctl_t   ctl,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] reg_q,
  output logic         rco
);
  logic [W-1:0] cnt_d;
  logic [W-1:0] reg_d;
  logic         cnt_ce;
  logic         reg_ce;

  assign cnt_ce = ctl.clr | ctl.step;
  assign reg_ce = ctl.clr | ctl.ld;
  assign rco    = ctl.step & (&cnt_q);

  always_comb begin
    cnt_d = cnt_q;
    reg_d = reg_q;
    if (ctl.clr) begin
      cnt_d = '0;
      reg_d = '0;
    end else begin
      if (ctl.step) cnt_d = cnt_q + 1'b1;
      if (ctl.ld)   reg_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      reg_q <= '0;
    end else begin
      if (cnt_ce) cnt_q <= cnt_d;
      if (reg_ce) reg_q <= reg_d;
    end
  end
endmodule

// File: rtl/cag_msb.sv
module cag_msb
  import cag_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  stage_ctl_t ctl,
  output logic       bit_q,
  output logic       reg_q
);
  logic bit_d;
  logic reg_d;
  logic bit_ce;
  logic reg_ce;

  assign bit_ce = ctl.clr | ctl.step;
  assign reg_ce = ctl.clr | ctl.ld;

  always_comb begin
    bit_d = bit_q;
    reg_d = reg_q;
    if (ctl.clr) begin
      bit_d = 1'b0;
      reg_d = 1'b0;
    end else begin
      if (ctl.step) bit_d = ~bit_q;
      if (ctl.ld)   reg_d = bit_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      reg_q <= 1'b0;
    end else begin
      if (bit_ce) bit_q <= bit_d;
      if (reg_ce) reg_q <= reg_d;
    end
  end
endmodule

// File: rtl/cascade_addr_gen.sv
module cascade_addr_gen
  import cag_pkg::*;
#(
  parameter int unsigned STAGE_W  = STAGE_W_DEF,
  parameter int unsigned N_STAGES = N_STAGES_DEF,
  localparam int unsigned LOW_W   = STAGE_W * N_STAGES,
  localparam int unsigned ADDR_W  = LOW_W + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_clr,
  input  logic                cnt_en,
  input  logic                cnt_clk_en,
  input  logic                reg_clk_en,
  input  logic                out_en,
  output logic [ADDR_W-1:0]   addr_o,
  output logic [N_STAGES-1:0] stage_rco_o,
  output logic                tc_o
);
  logic [1:0]        rst_pipe;
  logic              rst_sync_n;
  logic [N_STAGES:0] step_chain;
  logic [ADDR_W-1:0] cnt_addr;
  logic [ADDR_W-1:0] reg_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign step_chain[0] = cnt_en & cnt_clk_en;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    stage_ctl_t ctl;
    assign ctl.clr  = sync_clr;
    assign ctl.step = step_chain[i];
    assign ctl.ld   = reg_clk_en;

    cag_stage #(.W(STAGE_W)) u_stage (
      .clk   (clk),
      .rst_n (rst_sync_n),
      .ctl   (ctl),
      .cnt_q (cnt_addr[i*STAGE_W +: STAGE_W]),
      .reg_q (reg_addr[i*STAGE_W +: STAGE_W]),
      .rco   (step_chain[i+1])
    );
    assign stage_rco_o[i] = step_chain[i+1];
  end

  stage_ctl_t msb_ctl;
  assign msb_ctl.clr  = sync_clr;
  assign msb_ctl.step = step_chain[N_STAGES];
  assign msb_ctl.ld   = reg_clk_en;

  cag_msb u_msb (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .ctl   (msb_ctl),
    .bit_q (cnt_addr[ADDR_W-1]),
    .reg_q (reg_addr[ADDR_W-1])
  );

  assign tc_o   = &reg_addr;
  assign addr_o = out_en ? reg_addr : {ADDR_W{1'bz}};
endmodule

// File: rtl/cag_chk.sv
module cag_chk #(
  parameter int unsigned AW = 17,
  parameter int unsigned NS = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_clr,
  input logic          cnt_en,
  input logic          cnt_clk_en,
  input logic          reg_clk_en,
  input logic [AW-1:0] cnt_addr,
  input logic [AW-1:0] reg_addr,
  input logic [NS-1:0] stage_rco_o,
  input logic          tc_o
);
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && cnt_en && cnt_clk_en) |=> (cnt_addr == $past(cnt_addr) + 1'b1)); // R2
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && !(cnt_en && cnt_clk_en)) |=> $stable(cnt_addr)); // R10
  AST_REG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && reg_clk_en) |=> (reg_addr == $past(cnt_addr))); // R3
  AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && !reg_clk_en) |=> $stable(reg_addr)); // R3
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    sync_clr |=> (cnt_addr == '0 && reg_addr == '0)); // R9
  AST_TOP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && stage_rco_o[NS-1]) |=> (cnt_addr[AW-1] != $past(cnt_addr[AW-1]))); // R6
  AST_TOP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_clr && !stage_rco_o[NS-1]) |=> $stable(cnt_addr[AW-1])); // R6
  AST_TC_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_o) |-> $past(reg_clk_en)); // R7
endmodule

bind cascade_addr_gen cag_chk #(.AW(ADDR_W), .NS(N_STAGES)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .sync_clr    (sync_clr),
  .cnt_en      (cnt_en),
  .cnt_clk_en  (cnt_clk_en),
  .reg_clk_en  (reg_clk_en),
  .cnt_addr    (cnt_addr),
  .reg_addr    (reg_addr),
  .stage_rco_o (stage_rco_o),
  .tc_o        (tc_o)
);

// File: tb/sim_cascade_addr_gen.sv
`timescale 1ns/1ps
module sim_cascade_addr_gen;
  logic clk = 1'b0;
  logic rst_n, sync_clr, cnt_en, cnt_clk_en, reg_clk_en, out_en;
  wire  [16:0] addr_w;
  logic [1:0]  rco;
  logic        tc;

  int errors = 0;
  int checks = 0;

  logic [16:0] exp_cnt;
  logic [16:0] exp_reg;
  logic [1:0]  rco_pre;
  logic [1:0]  rco_exp_pre;

  always #5 clk = ~clk;

  for (genvar i = 0; i < 17; i++) begin : g_pd
    pulldown p (addr_w[i]);
  end

  cascade_addr_gen u0 (
    .clk(clk), .rst_n(rst_n), .sync_clr(sync_clr), .cnt_en(cnt_en),
    .cnt_clk_en(cnt_clk_en), .reg_clk_en(reg_clk_en), .out_en(out_en),
    .addr_o(addr_w), .stage_rco_o(rco), .tc_o(tc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock: apply inputs, capture carries before the edge, update model after it.
  task automatic cyc(input logic s, input logic e, input logic c, input logic r);
    sync_clr = s; cnt_en = e; cnt_clk_en = c; reg_clk_en = r;
    #2;
    rco_pre = rco;
    rco_exp_pre[0] = (exp_cnt[7:0] == 8'hFF) && e && c;
    rco_exp_pre[1] = rco_exp_pre[0] && (exp_cnt[15:8] == 8'hFF);
    @(posedge clk); #1;
    if (s) begin
      exp_cnt = '0; exp_reg = '0;
    end else begin
      if (r) exp_reg = exp_cnt;
      if (e && c) exp_cnt = exp_cnt + 1'b1;
    end
  endtask

  task automatic t_reset;
    rst_n = 1'b0; out_en = 1'b1;
    cyc(0, 1, 1, 1);
    exp_cnt = '0; exp_reg = '0;
    check("R1 addr in reset", addr_w, 0);
    check("R1 tc in reset", tc, 0);
    check("R1 rco in reset", rco, 0);
    rst_n = 1'b1;
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    cyc(0, 0, 0, 0);
    check("R1 addr after release", addr_w, 0);
  endtask

  task automatic t_lag;
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 5; k++) cyc(0, 1, 1, 1);
    check("R3 tied lag addr", addr_w, 4);
    cyc(0, 0, 0, 1);
    check("R3 register-only load", addr_w, 5);
  endtask

  task automatic t_hold;
    for (int k = 0; k < 3; k++) cyc(0, 0, 1, 0);
    cyc(0, 1, 0, 0);
    check("R10 rco with enable low", rco_pre, 0);
    cyc(0, 0, 0, 1);
    check("R10 count held", addr_w, 5);
    cyc(0, 1, 1, 0);
    cyc(0, 0, 0, 1);
    check("R2 single advance", addr_w, 6);
  endtask

  task automatic t_sclr;
    cyc(1, 1, 1, 1);
    check("R9 register cleared", addr_w, 0);
    cyc(0, 0, 0, 1);
    check("R9 counter cleared", addr_w, 0);
  endtask

  task automatic t_oe;
    for (int k = 0; k < 8; k++) cyc(0, 1, 1, 1);
    check("R8 value before float", addr_w, 7);
    out_en = 1'b0;
    cyc(0, 1, 1, 1);
    check("R8 floated reads pull level", addr_w, 0);
    out_en = 1'b1;
    #1;
    check("R8 value returns", addr_w, 32'(exp_reg));
    check("R8 kept loading", exp_reg, 8);
  endtask

  task automatic t_rco_gate;
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 255; k++) cyc(0, 1, 1, 0);
    cyc(0, 1, 0, 0);
    check("R4 rco gated by clock enable", rco_pre, 0);
    cyc(0, 1, 1, 1);
    check("R4 stage0 rco at 0xFF", rco_pre, 2'b01);
    cyc(0, 0, 0, 1);
    check("R5 carry into stage1", addr_w, 32'h100);
  endtask

  task automatic t_full_pass;
    logic seen_tc;
    logic seen_wrap;
    seen_tc = 1'b0; seen_wrap = 1'b0;
    cyc(1, 0, 0, 0);
    for (int k = 0; k < 131074; k++) begin
      cyc(0, 1, 1, 1);
      if (exp_cnt == 17'h10000) begin
        check("R4 both rco at 0xFFFF", rco_pre, 2'b11);
      end
      if (exp_reg == 17'h10000 && exp_cnt == 17'h10001) begin
        check("R6 bit16 set", addr_w, 32'h10000);
      end
      if (exp_reg == 17'h1FFFF) begin
        seen_tc = 1'b1;
        check("R7 tc at last address", tc, 1);
        check("R7 wrapped count", exp_cnt, 0);
      end
      if (exp_reg == 17'h1FFFE) check("R7 tc low before last", tc, 0);
      if (seen_tc && exp_reg == 17'h0 && !seen_wrap) begin
        seen_wrap = 1'b1;
        check("R7 address wraps to zero", addr_w, 0);
        check("R7 tc clears after wrap", tc, 0);
      end
    end
    check("R7 wrap observed", seen_wrap, 1);
  endtask

  initial begin
    sync_clr = 0; cnt_en = 0; cnt_clk_en = 0; reg_clk_en = 0; out_en = 1; rst_n = 0;
    exp_cnt = '0; exp_reg = '0; rco_pre = '0; rco_exp_pre = '0;
    t_reset();
    t_lag();
    t_hold();
    t_sclr();
    t_oe();
    t_rco_gate();
    t_full_pass();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_950_000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule